// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer that software programs through a small word-indexed register port. A clock-source selector chooses between two external tick-enable strobes, one for the fast system rate and one for the slow 32 kHz rate. A 12-bit prescaler then divides the chosen strobe. On each divided strobe the counter advances by one.

Three compare registers are checked against the counter. Each match, and each wrap of the counter past its top value, sets a sticky status flag. Software clears a flag by writing a 1 to it. A per-flag mask, together with the global run bit, decides whether the single level interrupt is raised.

The counter either runs freely through its full range or returns to zero after it reaches the first compare value. A control bit performs a partial soft reset. The low-power enable bits are kept in the control register but have no effect.

Top module: `gp_timer`

## Requirements
- R1: After hardware reset the control, prescaler, status and mask registers and the counter read 0, all three compare registers read all ones (zero-extended to 32 bits), the capture words at indices 7 and 8 read 0, and `irq` is 0.
- R2: A write to the control word (index 0) stores the value with bits 2, 4 and 10 to 15 forced to 0, so bit 15 always reads back as 0.
- R3: Control bits 8:6 choose the count source: codes 1 and 2 select `main_tick`, code 4 selects `slow_tick`, and any other code selects nothing, so the counter holds.
- R4: The prescaler (index 1) keeps the low 12 bits of a write. While control bit 0 is 1, the counter advances once for every (prescaler + 1) strobes of the selected source.
- R5: With control bit 9 set (free-run), an advance from the all-ones value gives 0 and sets status bit 5.
- R6: With control bit 9 clear (restart), the advance after the counter equals compare 1 gives 0.
- R7: Status bits 0, 1 and 2 set on the advance that brings the counter onto compare 1, 2 or 3 (indices 4, 5, 6). This happens whether or not the flag's interrupt is masked.
- R8: Writing the status word (index 2) clears each of bits 5:0 that is written as 1. A flag event in the same cycle as its clear leaves the flag set.
- R9: `irq` is high one cycle after (status AND mask at index 3) is non-zero while control bit 0 is 1, and low otherwise.
- R10: A control write with bit 15 set clears control bits 5:0, and the written value is kept in the other control bits. It also clears status, mask, prescaler and counter, and sets every compare register to all ones.
- R11: When control bit 0 is 0 the counter holds. A write that takes bit 0 from 0 to 1 with bit 1 set restarts the counter at 0; with bit 1 clear the count is kept.
- R12: A write to compare 1 while in restart mode restarts the counter at 0.
- R13: The counter word (index 9) is read-only; writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data valid the next cycle |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| main_tick | input | 1 | Fast-rate count strobe |
| slow_tick | input | 1 | Slow-rate count strobe |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the timer with an 8-bit counter. With that width the free-run wrap and the rollover flag come after 256 advances, and the bench drives and checks the full cycle. The prescaler keeps its default 12-bit width, so the bench can write a 13-bit value and see it truncated. Both strobe inputs are driven separately, and every source code class is covered: fast, slow and none. The same-cycle case of a flag clear racing a compare match is driven by a directed test.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // register word indices
  localparam logic [3:0] IDX_CTRL = 4'd0;
  localparam logic [3:0] IDX_PRE  = 4'd1;
  localparam logic [3:0] IDX_STAT = 4'd2;
  localparam logic [3:0] IDX_MASK = 4'd3;
  localparam logic [3:0] IDX_CMP1 = 4'd4;
  localparam logic [3:0] IDX_CMP2 = 4'd5;
  localparam logic [3:0] IDX_CMP3 = 4'd6;
  localparam logic [3:0] IDX_CAP1 = 4'd7;
  localparam logic [3:0] IDX_CAP2 = 4'd8;
  localparam logic [3:0] IDX_CNT  = 4'd9;

  // control bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_ZEROEN = 1;
  localparam int CB_SRC_LO = 6;
  localparam int CB_FREE   = 9;
  localparam int CB_SOFT   = 15;

  // control bits always written as zero (includes the self-clearing soft reset)
  localparam logic [31:0] CTRL_FORCE0 = 32'h0000_FC14;
  // control bits cleared by a soft reset
  localparam logic [31:0] CTRL_SOFTCLR = 32'h0000_003F;

  // status layout
  localparam int STAT_W  = 6;
  localparam int SB_WRAP = 5;
  localparam int NCMP    = 3;

  // count source codes
  localparam logic [2:0] SRC_FAST_A = 3'd1;
  localparam logic [2:0] SRC_FAST_B = 3'd2;
  localparam logic [2:0] SRC_SLOW   = 3'd4;
endpackage

// File: rtl/gpt_tick_div.sv
module gpt_tick_div
  import gpt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [2:0]       src,
  input  logic             main_tick,
  input  logic             slow_tick,
  input  logic [PRE_W-1:0] pre,
  output logic             adv
);
  logic             sel_tick;
  logic [PRE_W-1:0] div_q;
  logic             div_end;

  always_comb begin
    case (src)
      SRC_FAST_A, SRC_FAST_B: sel_tick = main_tick;
      SRC_SLOW:               sel_tick = slow_tick;
      default:                sel_tick = 1'b0;
    endcase
  end

  assign div_end = (div_q >= pre);
  assign adv     = run & sel_tick & div_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run && sel_tick) begin
      div_q <= div_end ? '0 : div_q + 1'b1;
    end
  end

  // R3: an unselected or undefined source never produces an advance
  a_r3_no_source: assert property (@(posedge clk) disable iff (rst)
    !(src == SRC_FAST_A || src == SRC_FAST_B || src == SRC_SLOW) |-> !adv);
  // R4: the divider restarts after every advance
  a_r4_div_restart: assert property (@(posedge clk) disable iff (rst)
    adv |=> div_q == '0);
endmodule

// File: rtl/gpt_count_cmp.sv
module gpt_count_cmp
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       adv,
  input  logic                       restart_mode,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCMP-1:0]            hit,
  output logic                       wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             back_to_zero;

  assign back_to_zero = restart_mode && (cnt_q == cmp_vals[0]);
  assign cnt_nxt      = back_to_zero ? '0 : cnt_q + 1'b1;
  assign wrap         = adv && (cnt_q == CNT_TOP);
  assign cnt          = cnt_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = adv && (cnt_nxt == cmp_vals[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R5: a wrap always lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> cnt_q == '0);
  // R6: restart mode returns to zero after the first compare value
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && restart_mode && cnt_q == cmp_vals[0] && !clr) |=> cnt_q == '0);
  // R11: without an advance or a clear the count holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        main_tick,
  input  logic        slow_tick,
  output logic        irq
);
  localparam int DATA_W = 32;

  logic [DATA_W-1:0]           ctrl_q;
  logic [PRE_W-1:0]            pre_q;
  logic [STAT_W-1:0]           stat_q;
  logic [STAT_W-1:0]           mask_q;
  logic [NCMP-1:0][CNT_W-1:0]  cmp_q;
  logic                        irq_q;
  logic [DATA_W-1:0]           rdata_q;

  logic [CNT_W-1:0]  cnt;
  logic [NCMP-1:0]   hit;
  logic              cnt_wrap;
  logic              adv;

  logic              wr_ctrl, soft_rst, run_rise, cmp1_restart, clr_cnt;
  logic [DATA_W-1:0] ctrl_wval;
  logic [STAT_W-1:0] stat_evt, stat_clr;

  assign wr_ctrl      = wr_en && (addr == IDX_CTRL);
  assign ctrl_wval    = wdata & ~CTRL_FORCE0;
  assign soft_rst     = wr_ctrl && wdata[CB_SOFT];
  assign run_rise     = wr_ctrl && !soft_rst && wdata[CB_RUN] && wdata[CB_ZEROEN]
                        && !ctrl_q[CB_RUN];
  assign cmp1_restart = wr_en && (addr == IDX_CMP1) && !ctrl_q[CB_FREE];
  assign clr_cnt      = soft_rst || run_rise || cmp1_restart;

  gpt_tick_div #(.PRE_W(PRE_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_cnt),
    .run       (ctrl_q[CB_RUN]),
    .src       (ctrl_q[CB_SRC_LO+2:CB_SRC_LO]),
    .main_tick (main_tick),
    .slow_tick (slow_tick),
    .pre       (pre_q),
    .adv       (adv)
  );

  gpt_count_cmp #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr_cnt),
    .adv          (adv),
    .restart_mode (!ctrl_q[CB_FREE]),
    .cmp_vals     (cmp_q),
    .cnt          (cnt),
    .hit          (hit),
    .wrap         (cnt_wrap)
  );

  always_comb begin
    stat_evt = '0;
    if (!clr_cnt) begin
      stat_evt[NCMP-1:0] = hit;
      stat_evt[SB_WRAP]  = cnt_wrap;
    end
    stat_clr = (wr_en && addr == IDX_STAT) ? wdata[STAT_W-1:0] : '0;
  end

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      cmp_q  <= '1;
    end else if (soft_rst) begin
      ctrl_q <= ctrl_wval & ~CTRL_SOFTCLR;
      pre_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      cmp_q  <= '1;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_evt;
      if (wr_en) begin
        case (addr)
          IDX_CTRL: ctrl_q <= ctrl_wval;
          IDX_PRE:  pre_q  <= wdata[PRE_W-1:0];
          IDX_MASK: mask_q <= wdata[STAT_W-1:0];
          IDX_CMP1: cmp_q[0] <= wdata[CNT_W-1:0];
          IDX_CMP2: cmp_q[1] <= wdata[CNT_W-1:0];
          IDX_CMP3: cmp_q[2] <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // registered interrupt and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= (|(stat_q & mask_q)) && ctrl_q[CB_RUN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= '0;
      case (addr)
        IDX_CTRL: rdata_q <= ctrl_q;
        IDX_PRE:  rdata_q[PRE_W-1:0]  <= pre_q;
        IDX_STAT: rdata_q[STAT_W-1:0] <= stat_q;
        IDX_MASK: rdata_q[STAT_W-1:0] <= mask_q;
        IDX_CMP1: rdata_q[CNT_W-1:0]  <= cmp_q[0];
        IDX_CMP2: rdata_q[CNT_W-1:0]  <= cmp_q[1];
        IDX_CMP3: rdata_q[CNT_W-1:0]  <= cmp_q[2];
        IDX_CNT:  rdata_q[CNT_W-1:0]  <= cnt;
        default: ;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R2: forced-zero control bits never hold a 1
  a_r2_ctrl_clean: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & CTRL_FORCE0) == '0);
  // R8: a rollover event survives a same-cycle clear
  a_r8_wrap_wins: assert property (@(posedge clk) disable iff (rst)
    (cnt_wrap && !clr_cnt) |=> stat_q[SB_WRAP]);
  // R8: a compare-1 event survives a same-cycle clear
  a_r8_hit_wins: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && !clr_cnt) |=> stat_q[0]);
  // R9: interrupt tracks masked status while running, one cycle later
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past((|(stat_q & mask_q)) && ctrl_q[CB_RUN]));
  // R10: soft reset empties status, mask and counter
  a_r10_soft: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (stat_q == '0 && mask_q == '0 && cnt == '0 && !ctrl_q[CB_RUN]));
  // R12: compare-1 write in restart mode zeroes the count
  a_r12_cmp1_restart: assert property (@(posedge clk) disable iff (rst)
    cmp1_restart |=> cnt == '0);
endmodule

// File: tb/gp_timer_tb_top.sv
module gp_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_MT  = 3'd2;
  localparam logic [2:0] OP_ST  = 3'd3;
  localparam logic [2:0] OP_IRQ = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 90;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 4'd0, 32'h0, 32'h0, 4'd1},          // R1 control
    '{OP_RD, 4'd4, 32'h0, 32'hFF, 4'd1},         // R1 compare 1
    '{OP_RD, 4'd6, 32'h0, 32'hFF, 4'd1},         // R1 compare 3
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd1},          // R1 counter
    '{OP_RD, 4'd7, 32'h0, 32'h0, 4'd1},          // R1 capture
    '{OP_RD, 4'd2, 32'h0, 32'h0, 4'd1},          // R1 status
    '{OP_IRQ, 4'd0, 32'h0, 32'h0, 4'd1},         // R1 irq
    '{OP_WR, 4'd0, 32'hFFFF7FFE, 32'h0, 4'd2},
    '{OP_RD, 4'd0, 32'h0, 32'hFFFF03EA, 4'd2},   // R2 masking
    '{OP_WR, 4'd0, 32'h0, 32'h0, 4'd2},
    '{OP_WR, 4'd1, 32'h2, 32'h0, 4'd4},
    '{OP_WR, 4'd0, 32'h241, 32'h0, 4'd3},
    '{OP_MT, 4'd0, 32'd6, 32'h0, 4'd4},
    '{OP_RD, 4'd9, 32'h0, 32'h2, 4'd4},          // R4 divide by 3
    '{OP_ST, 4'd0, 32'd6, 32'h0, 4'd3},
    '{OP_RD, 4'd9, 32'h0, 32'h2, 4'd3},          // R3 slow ignored on code 1
    '{OP_WR, 4'd0, 32'h281, 32'h0, 4'd3},
    '{OP_MT, 4'd0, 32'd3, 32'h0, 4'd3},
    '{OP_RD, 4'd9, 32'h0, 32'h3, 4'd3},          // R3 code 2 fast
    '{OP_WR, 4'd0, 32'h301, 32'h0, 4'd3},
    '{OP_ST, 4'd0, 32'd3, 32'h0, 4'd3},
    '{OP_MT, 4'd0, 32'd3, 32'h0, 4'd3},
    '{OP_RD, 4'd9, 32'h0, 32'h4, 4'd3},          // R3 code 4 slow only
    '{OP_WR, 4'd0, 32'h3C1, 32'h0, 4'd3},
    '{OP_MT, 4'd0, 32'd3, 32'h0, 4'd3},
    '{OP_ST, 4'd0, 32'd3, 32'h0, 4'd3},
    '{OP_RD, 4'd9, 32'h0, 32'h4, 4'd3},          // R3 code 7 none
    '{OP_WR, 4'd1, 32'h1FFF, 32'h0, 4'd4},
    '{OP_RD, 4'd1, 32'h0, 32'hFFF, 4'd4},        // R4 12-bit prescaler
    '{OP_WR, 4'd1, 32'h0, 32'h0, 4'd4},
    '{OP_WR, 4'd0, 32'h241, 32'h0, 4'd7},
    '{OP_WR, 4'd4, 32'd30, 32'h0, 4'd7},
    '{OP_WR, 4'd5, 32'd10, 32'h0, 4'd7},
    '{OP_WR, 4'd6, 32'd20, 32'h0, 4'd7},
    '{OP_MT, 4'd0, 32'd6, 32'h0, 4'd7},
    '{OP_RD, 4'd9, 32'h0, 32'd10, 4'd7},         // R7 count kept on compare 1 write in free-run
    '{OP_RD, 4'd2, 32'h0, 32'h02, 4'd7},         // R7 flag while masked
    '{OP_IRQ, 4'd0, 32'h0, 32'h0, 4'd9},         // R9 masked
    '{OP_WR, 4'd3, 32'h02, 32'h0, 4'd9},
    '{OP_IRQ, 4'd0, 32'h0, 32'h1, 4'd9},         // R9 unmasked
    '{OP_WR, 4'd2, 32'h02, 32'h0, 4'd8},
    '{OP_IRQ, 4'd0, 32'h0, 32'h0, 4'd8},         // R8 cleared
    '{OP_MT, 4'd0, 32'd10, 32'h0, 4'd7},
    '{OP_RD, 4'd2, 32'h0, 32'h04, 4'd7},         // R7 compare 3
    '{OP_MT, 4'd0, 32'd10, 32'h0, 4'd7},
    '{OP_RD, 4'd2, 32'h0, 32'h05, 4'd7},         // R7 compare 1
    '{OP_MT, 4'd0, 32'd225, 32'h0, 4'd5},
    '{OP_RD, 4'd9, 32'h0, 32'hFF, 4'd5},         // R5 at top
    '{OP_RD, 4'd2, 32'h0, 32'h05, 4'd5},         // R5 no flag yet
    '{OP_MT, 4'd0, 32'd1, 32'h0, 4'd5},
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd5},          // R5 wrapped
    '{OP_RD, 4'd2, 32'h0, 32'h25, 4'd5},         // R5 rollover flag
    '{OP_WR, 4'd2, 32'h01, 32'h0, 4'd8},
    '{OP_RD, 4'd2, 32'h0, 32'h24, 4'd8},         // R8 partial clear
    '{OP_WR, 4'd2, 32'h3F, 32'h0, 4'd8},
    '{OP_WR, 4'd0, 32'h041, 32'h0, 4'd6},
    '{OP_MT, 4'd0, 32'd5, 32'h0, 4'd6},
    '{OP_RD, 4'd9, 32'h0, 32'd5, 4'd6},
    '{OP_WR, 4'd4, 32'd7, 32'h0, 4'd12},
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd12},         // R12 restart on compare 1 write
    '{OP_MT, 4'd0, 32'd7, 32'h0, 4'd6},
    '{OP_RD, 4'd9, 32'h0, 32'd7, 4'd6},          // R6 reaches compare 1
    '{OP_MT, 4'd0, 32'd1, 32'h0, 4'd6},
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd6},          // R6 back to zero
    '{OP_RD, 4'd2, 32'h0, 32'h01, 4'd6},         // R6 flag
    '{OP_MT, 4'd0, 32'd3, 32'h0, 4'd9},
    '{OP_WR, 4'd3, 32'h01, 32'h0, 4'd9},
    '{OP_IRQ, 4'd0, 32'h0, 32'h1, 4'd9},         // R9 high
    '{OP_WR, 4'd0, 32'h040, 32'h0, 4'd9},
    '{OP_IRQ, 4'd0, 32'h0, 32'h0, 4'd9},         // R9 gated by run bit
    '{OP_MT, 4'd0, 32'd5, 32'h0, 4'd11},
    '{OP_RD, 4'd9, 32'h0, 32'd3, 4'd11},         // R11 stopped holds
    '{OP_WR, 4'd0, 32'h041, 32'h0, 4'd11},
    '{OP_RD, 4'd9, 32'h0, 32'd3, 4'd11},         // R11 start keeps count
    '{OP_WR, 4'd0, 32'h040, 32'h0, 4'd11},
    '{OP_WR, 4'd0, 32'h043, 32'h0, 4'd11},
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd11},         // R11 start zeroes count
    '{OP_MT, 4'd0, 32'd2, 32'h0, 4'd13},
    '{OP_WR, 4'd9, 32'h55, 32'h0, 4'd13},
    '{OP_RD, 4'd9, 32'h0, 32'd2, 4'd13},         // R13 read-only
    '{OP_WR, 4'd1, 32'h3, 32'h0, 4'd10},
    '{OP_WR, 4'd0, 32'h8243, 32'h0, 4'd10},
    '{OP_RD, 4'd0, 32'h0, 32'h240, 4'd10},       // R10 control
    '{OP_RD, 4'd1, 32'h0, 32'h0, 4'd10},         // R10 prescaler
    '{OP_RD, 4'd2, 32'h0, 32'h0, 4'd10},         // R10 status
    '{OP_RD, 4'd3, 32'h0, 32'h0, 4'd10},         // R10 mask
    '{OP_RD, 4'd4, 32'h0, 32'hFF, 4'd10},        // R10 compare 1
    '{OP_RD, 4'd5, 32'h0, 32'hFF, 4'd10},        // R10 compare 2
    '{OP_RD, 4'd9, 32'h0, 32'h0, 4'd10},         // R10 counter
    '{OP_IRQ, 4'd0, 32'h0, 32'h0, 4'd10}         // R10 irq
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        main_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic        irq;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer #(.CNT_W(CNT_W), .PRE_W(12)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .main_tick (main_tick),
    .slow_tick (slow_tick),
    .irq       (irq)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] expv);
    nchk++;
    if (got !== expv) begin
      nerr++;
      $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, got, expv);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic do_ticks(input int n, input bit slow);
    if (n > 0) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else main_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0;
      main_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_wr(VEC[i].idx, VEC[i].data);
        OP_RD: begin
          do_rd(VEC[i].idx, v);
          check(int'(VEC[i].req), v, VEC[i].expv);
        end
        OP_MT: do_ticks(int'(VEC[i].data), 1'b0);
        OP_ST: do_ticks(int'(VEC[i].data), 1'b1);
        OP_IRQ: begin
          @(negedge clk);
          check(int'(VEC[i].req), {31'b0, irq}, VEC[i].expv);
        end
        default: ;
      endcase
    end

    // R8: a status clear landing on the same edge as a compare match loses
    do_wr(4'd0, 32'h241);
    do_wr(4'd5, 32'd5);
    do_ticks(4, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd2; wdata = 32'h02; main_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; main_tick = 1'b0;
    do_rd(4'd9, v);
    check(8, v, 32'd5);
    do_rd(4'd2, v);
    check(8, v, 32'h02);

    // R1: hardware reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_rd(4'd0, v);
    check(1, v, 32'h0);
    do_rd(4'd5, v);
    check(1, v, 32'hFF);
    do_rd(4'd9, v);
    check(1, v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule